// File: doc/BRIEF.md
# Power Controller with Masked-Write Output Pins

This peripheral sits on a simple 32-bit register bus. The bus carries a byte address, write data, a write strobe and a read strobe, and returns read data in the same cycle. It drives two general-purpose output pins and raises a single power-off request line.

The pins are updated through a mask carried in the upper half of the same write. A pin changes only when its mask bit is set in that write, so one pin can be driven without knowing the state of the other. The pin register cannot be read back.

Three one-bit control registers gate the power-off request: a soft-reset release, a main-clock enable and a power-off command. The request is raised only when the command arrives after the release and clock-enable bits are both already set. Once raised, it stays high until a hardware reset.

Top module: `pwrctl_top`

## Requirements
- R1: After reset `rst_n` is deasserted, both output pins are 0, the release, clock-enable and power-off bits are 0, and `pwr_off_req` is 0.
- R2: A write to byte offset 0x80 sets pin i to write-data bit i (i = 0, 1) when write-data bit 16+i is 1. A pin whose bit 16+i is 0 keeps its value. The change is visible on the pin one clock edge after the write.
- R3: A read from offset 0x80 returns all zeros, whatever the pin states are.
- R4: Bit 0 of a write to offset 0x00 sets the soft-reset release bit, and bit 0 of a write to offset 0x04 sets the main-clock enable bit. Each may be written to 0 or 1. A read of either offset returns the bit in read-data bit 0, with all other read-data bits 0.
- R5: A write to offset 0x50 with bit 0 set, made while the release and clock-enable bits already hold 1, raises `pwr_off_req` one clock edge later. A read of 0x50 then returns 1 in bit 0.
- R6: A write to offset 0x50 with bit 0 set is ignored if either the release bit or the clock-enable bit is 0 at the time of the write. `pwr_off_req` stays 0 and a read of 0x50 returns 0.
- R7: Once `pwr_off_req` is 1, it stays 1 until reset. Writing 0 to 0x50, 0x00 or 0x04 does not clear it.
- R8: Writes to any byte address other than 0x00, 0x04, 0x50 and 0x80 change no pin and no register, and reads from them return zero.
- R9: `bus_rdata` is zero in any cycle where `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, valid while `bus_re` is high |
| pin_out | output | 2 | General-purpose output pins |
| pwr_off_req | output | 1 | Sticky power-off request |

## Verification
The assertions assume that `bus_we` and `bus_re` are never high in the same cycle. They also assume that the bus inputs are stable around the clock edge and hold known values after reset.

The stimulus meets these assumptions by changing every input on the falling edge and issuing only one access per transaction. The power-off gating is exercised by issuing the three control writes in the required order. It is also exercised with a step missing, and again after a mid-run reset.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NUM_PINS = 2;
  localparam int MASK_LSB = 16;

  localparam logic [ADDR_W-1:0] OFS_RELEASE = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CLKEN   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_POWOFF  = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_PINS    = 8'h80;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RELEASE,
    SEL_CLKEN,
    SEL_POWOFF,
    SEL_PINS
  } reg_sel_e;
endpackage

// File: rtl/pwrctl_regdec.sv
module pwrctl_regdec
  import pwrctl_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output reg_sel_e      sel
);
  always_comb begin
    if (addr == AW'(OFS_RELEASE))      sel = SEL_RELEASE;
    else if (addr == AW'(OFS_CLKEN))   sel = SEL_CLKEN;
    else if (addr == AW'(OFS_POWOFF))  sel = SEL_POWOFF;
    else if (addr == AW'(OFS_PINS))    sel = SEL_PINS;
    else                               sel = SEL_NONE;
  end
endmodule

// File: rtl/pwrctl_pinmask.sv
module pwrctl_pinmask #(
  parameter int NP = 2,
  parameter int DW = 32,
  parameter int ML = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [NP-1:0] pins
);
  localparam int TOP_MASK = ML + NP - 1;

  logic [NP-1:0] mask;
  assign mask = wdata[TOP_MASK:ML];

  for (genvar i = 0; i < NP; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pins[i] <= 1'b0;
      else if (wr && mask[i])    pins[i] <= wdata[i];
    end

    assert_masked_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr && mask[i]) |=> $stable(pins[i]));
    assert_masked_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && mask[i]) |=> (pins[i] == $past(wdata[i])));
  end
endmodule

// File: rtl/pwrctl_offgate.sv
module pwrctl_offgate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_release,
  input  logic wr_clken,
  input  logic wr_powoff,
  input  logic wbit,
  output logic release_q,
  output logic clken_q,
  output logic req_q
);
  logic arm_ok;
  assign arm_ok = release_q && clken_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_q <= 1'b0;
      clken_q   <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      if (wr_release) release_q <= wbit;
      if (wr_clken)   clken_q   <= wbit;
      if (wr_powoff && wbit && arm_ok) req_q <= 1'b1;
    end
  end

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> req_q);
  assert_gate_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(release_q && clken_q && wr_powoff));
  assert_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_powoff && wbit && release_q && clken_q) |=> req_q);
endmodule

// File: rtl/pwrctl_top.sv
module pwrctl_top
  import pwrctl_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int NP = NUM_PINS,
  parameter int ML = MASK_LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  input  logic          bus_re,
  output logic [DW-1:0] bus_rdata,
  output logic [NP-1:0] pin_out,
  output logic          pwr_off_req
);
  reg_sel_e sel;
  logic release_q, clken_q;

  pwrctl_regdec #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  pwrctl_pinmask #(.NP(NP), .DW(DW), .ML(ML)) u_pins (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_we && (sel == SEL_PINS)),
    .wdata (bus_wdata),
    .pins  (pin_out)
  );

  pwrctl_offgate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_release (bus_we && (sel == SEL_RELEASE)),
    .wr_clken   (bus_we && (sel == SEL_CLKEN)),
    .wr_powoff  (bus_we && (sel == SEL_POWOFF)),
    .wbit       (bus_wdata[0]),
    .release_q  (release_q),
    .clken_q    (clken_q),
    .req_q      (pwr_off_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      unique case (sel)
        SEL_RELEASE: bus_rdata[0] = release_q;
        SEL_CLKEN:   bus_rdata[0] = clken_q;
        SEL_POWOFF:  bus_rdata[0] = pwr_off_req;
        default:     bus_rdata    = '0;
      endcase
    end
  end

  assert_pin_unreadable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == AW'(OFS_PINS)) |-> (bus_rdata == '0));
  assert_unmapped_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_NONE) |=> ($stable(pin_out) && $stable(pwr_off_req)
                                     && $stable(release_q) && $stable(clken_q)));
  assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == '0));
  assert_ctrl_rdata_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |-> (bus_rdata[DW-1:1] == '0));
endmodule

// File: tb/pwrctl_top_bench.sv
module pwrctl_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  pin_out;
  logic        pwr_off_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwrctl_top u_pwrctl_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pwr_off_req(pwr_off_req)
  );

  typedef struct packed {
    logic [7:0]  addr;
    logic [31:0] data;
    logic [1:0]  pins;
    logic        req;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'h80, 32'h0001_0001, 2'b01, 1'b0, 4'd2},  // R2 pin0 only
    '{8'h80, 32'h0002_0002, 2'b11, 1'b0, 4'd2},  // R2 pin1 only
    '{8'h80, 32'h0000_0000, 2'b11, 1'b0, 4'd2},  // R2 no mask bits
    '{8'h80, 32'h0001_0000, 2'b10, 1'b0, 4'd2},  // R2 clear pin0
    '{8'h80, 32'h0000_0003, 2'b10, 1'b0, 4'd2},  // R2 data without mask
    '{8'h80, 32'h0003_0000, 2'b00, 1'b0, 4'd2},  // R2 clear both
    '{8'h80, 32'h0003_0003, 2'b11, 1'b0, 4'd2},  // R2 set both
    '{8'h84, 32'h0003_0000, 2'b11, 1'b0, 4'd8},  // R8 unmapped write
    '{8'h50, 32'h0000_0001, 2'b11, 1'b0, 4'd6},  // R6 nothing armed
    '{8'h00, 32'h0000_0001, 2'b11, 1'b0, 4'd4},  // R4 release
    '{8'h50, 32'h0000_0001, 2'b11, 1'b0, 4'd6},  // R6 clock missing
    '{8'h04, 32'h0000_0001, 2'b11, 1'b0, 4'd4},  // R4 clock enable
    '{8'h50, 32'h0000_0001, 2'b11, 1'b1, 4'd5},  // R5 armed command
    '{8'h50, 32'h0000_0000, 2'b11, 1'b1, 4'd7},  // R7 write zero
    '{8'h00, 32'h0000_0000, 2'b11, 1'b1, 4'd7}   // R7 drop release
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    logic [31:0] r;
    do_reset();
    // R1 reset state
    chk("R1 pins", 32'(pin_out), 32'h0);
    chk("R1 req", 32'(pwr_off_req), 32'h0);
    rd(8'h00, r); chk("R1 release", r, 32'h0);
    rd(8'h04, r); chk("R1 clken", r, 32'h0);
    rd(8'h50, r); chk("R1 powoff", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].data);
      chk($sformatf("R%0d vec%0d pins", VECS[i].rq, i), 32'(pin_out), 32'(VECS[i].pins));
      chk($sformatf("R%0d vec%0d req", VECS[i].rq, i), 32'(pwr_off_req), 32'(VECS[i].req));
    end

    // R3 pins high yet unreadable
    rd(8'h80, r); chk("R3 pin read", r, 32'h0);
    // R4 readback
    rd(8'h00, r); chk("R4 release zero", r, 32'h0);
    rd(8'h04, r); chk("R4 clken one", r, 32'h1);
    // R5 power-off readback
    rd(8'h50, r); chk("R5 powoff read", r, 32'h1);
    // R8 unmapped reads
    rd(8'h84, r); chk("R8 unmapped read", r, 32'h0);
    rd(8'h51, r); chk("R8 unaligned read", r, 32'h0);
    // R9 idle read data
    @(negedge clk); bus_addr = 8'h04; #1;
    chk("R9 idle rdata", bus_rdata, 32'h0);

    // R1 mid-run reset clears everything
    do_reset();
    chk("R1 re-reset pins", 32'(pin_out), 32'h0);
    chk("R1 re-reset req", 32'(pwr_off_req), 32'h0);
    // R6 clock enabled only
    wr(8'h04, 32'h1);
    wr(8'h50, 32'h1);
    chk("R6 only clock", 32'(pwr_off_req), 32'h0);
    rd(8'h50, r); chk("R6 powoff read", r, 32'h0);
    // R5 completing order afterwards
    wr(8'h00, 32'h1);
    wr(8'h50, 32'h1);
    chk("R5 late arm", 32'(pwr_off_req), 32'h1);
    // R7 clearing clock does not drop request
    wr(8'h04, 32'h0);
    chk("R7 clock cleared", 32'(pwr_off_req), 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule